// File: doc/BRIEF.md
# Asymmetric-latency bank request scheduler

This block orders the traffic for a single bank of a memory whose cell writes take several times longer than its reads. Incoming requests are sorted into a read queue and a write queue. Each time the bank is idle, one service action is chosen: send a read to the bank, send the oldest write to the bank, or answer a read directly from the write queue.

Reads normally win, because the requester waits on them and writes can sit in a buffer. That preference holds only while the write queue stays below a high-water mark, set as a percentage of its depth. At or above that mark, the block drains writes oldest-first and flags each one as forced. A write that arrives for an address already queued updates the queued entry instead of taking a new slot. A read to a queued address is answered from the queue and does not touch the bank.

The bank itself is represented by a fixed-latency responder inside the block. It has separate read and write service times and does one operation at a time. Once a write has started, nothing interrupts it.

Top module: `asym_bank_scheduler`

## Requirements
- R1: After reset both queues are empty, `req_ready` is 1, and `issue_valid` and `rsp_valid` are 0.
- R2: While the write queue holds fewer entries than the high-water mark, a pending read is serviced before any pending write whenever the bank is idle.
- R3: The high-water mark is ceil(WRQ_DEPTH*HIGH_PCT/100) entries. At or above it, every service action is a write issue with `issue_forced` at 1. `issue_forced` is 0 on every other issue.
- R4: Writes are issued to the bank in the order their entries were first allocated. `issue_addr` and `issue_wdata` carry that entry's contents.
- R5: When the read at the head of the read queue matches the address of a write-queue entry and the bank is idle, the read is answered with that entry's data one cycle later, and `issue_valid` stays 0 for it.
- R6: A write to an address already in the write queue replaces that entry's data without changing its place in issue order or taking a new slot. A write that has already left for the bank is not an entry.
- R7: `req_ready` is 0 exactly when either queue is full. A request offered while `req_ready` is 0 is dropped.
- R8: The bank performs one operation at a time. No request is issued while an operation is in progress, so a read that arrives during a write waits for that write to finish.
- R9: A read issued on a clock edge returns `rsp_valid` for one cycle after RD_LAT further edges. A write occupies the bank for WR_LAT edges.
- R10: Responses appear one per cycle, in the order reads are serviced, and carry the request's tag. Their data is the value of the latest write to that address accepted before the read was serviced (zero if none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered this cycle |
| req_ready | output | 1 | Request will be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | TAG_W | Read tag returned with the response |
| issue_valid | output | 1 | An operation starts at the bank this cycle |
| issue_write | output | 1 | Issued operation is a write |
| issue_forced | output | 1 | Issued write was forced by the high-water mark |
| issue_addr | output | ADDR_W | Issued address |
| issue_wdata | output | DATA_W | Issued write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_data | output | DATA_W | Read data |

## Verification
The bench builds the block with a 16-word address space, a 4-entry read queue, an 8-entry write queue and an 80 % mark (7 entries), a read time of 3 cycles and a write time of 12. With the short queues, full-queue back-pressure and forced draining can be reached within a few dozen cycles. The small address space makes read hits and write merges frequent under random traffic. Because the write time is four times the read time, write bursts build up the queue while reads keep arriving.

// File: rtl/asym_sched_pkg.sv
// Shared definitions for the asymmetric bank scheduler.
// Assumes: HIGH_PCT lies in 1..100.
package asym_sched_pkg;

    // Service action chosen when the bank is idle.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_RD_BANK = 2'd1,
        ACT_WR_BANK = 2'd2,
        ACT_FORWARD = 2'd3
    } sched_act_e;

    // Entry count at which draining becomes forced: ceil(depth*pct/100).
    function automatic int high_mark(input int depth, input int pct);
        return (depth * pct + 99) / 100;
    endfunction

endpackage

// File: rtl/sched_rd_fifo.sv
// Read request queue: plain first-in first-out storage of packed {addr, tag}.
// Assumes: push is never asserted while full (the top gates it with ready);
// pop is never asserted while empty.
module sched_rd_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic             full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [PW-1:0]    head, tail;
    logic [CW-1:0]    count;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_data = slot[head];
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));

    // Advance pointers, store new entries and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (pop) begin
                head <= nxt(head);
            end
            if (push) begin
                slot[tail] <= push_data;
                tail       <= nxt(tail);
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end

    a_r7_rd_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r10_rd_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/sched_wr_queue.sv
// Write queue with address search.
// Entries leave only from the head, so they leave in allocation order.
// A push whose address matches a live entry (not the one leaving this cycle)
// rewrites that entry's data in place. A lookup port returns the data of the
// youngest entry matching a read address.
// Assumes: an allocating push never arrives while full; pop only when not empty.
module sched_wr_queue #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [ADDR_W-1:0]           push_addr,
    input  logic [DATA_W-1:0]           push_data,
    input  logic                        pop,
    output logic [ADDR_W-1:0]           head_addr,
    output logic [DATA_W-1:0]           head_data,
    output logic                        empty,
    output logic                        full,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    input  logic [ADDR_W-1:0]           look_addr,
    output logic                        look_hit,
    output logic [DATA_W-1:0]           look_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  vld;
    logic [PW-1:0]     head, tail;
    logic              merge_hit;
    logic [PW-1:0]     merge_idx;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_addr = addr_q[head];
    assign head_data = data_q[head];
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));

    // Find a live entry that an incoming write should merge into.
    always_comb begin
        merge_hit = 1'b0;
        merge_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && addr_q[i] == push_addr && !(pop && PW'(i) == head)) begin
                merge_hit = 1'b1;
                merge_idx = PW'(i);
            end
        end
    end

    // Scan from oldest to youngest so the youngest match supplies read data.
    always_comb begin
        int idx;
        look_hit  = 1'b0;
        look_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = int'(head) + k;
            if (idx >= DEPTH) idx = idx - DEPTH;
            if (vld[PW'(idx)] && addr_q[PW'(idx)] == look_addr) begin
                look_hit  = 1'b1;
                look_data = data_q[PW'(idx)];
            end
        end
    end

    // Retire the head, merge or allocate, and keep the entry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            vld   <= '0;
        end else begin
            if (pop) begin
                vld[head] <= 1'b0;
                head      <= nxt(head);
            end
            if (push && merge_hit) begin
                data_q[merge_idx] <= push_data;
            end else if (push) begin
                vld[tail]    <= 1'b1;
                addr_q[tail] <= push_addr;
                data_q[tail] <= push_data;
                tail         <= nxt(tail);
            end
            if (push && !merge_hit && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !(push && !merge_hit)) begin
                count <= count - 1'b1;
            end
        end
    end

    a_r7_wr_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !merge_hit) |-> !full);
    a_r6_merge_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push && merge_hit && !pop) |=> (count == $past(count)));
    a_r4_pop_only_live: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/sched_bank_model.sv
// Fixed-latency stand-in for the bank's cell array.
// An accepted operation holds the bank for RD_LAT or WR_LAT edges. A write
// lands in storage on its last edge; a read samples storage on its last edge
// and presents a one-cycle response after it. Storage resets to zero.
// Assumes: issue_valid only when busy is 0; both latencies are at least 1.
module sched_bank_model #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int RD_LAT = 1000,
    parameter int WR_LAT = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              issue_write,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [DATA_W-1:0] issue_wdata,
    input  logic [TAG_W-1:0]  issue_tag,
    output logic              busy,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int MAX_LAT = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
    localparam int LW      = $clog2(MAX_LAT + 1);
    localparam int WORDS   = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [WORDS];
    logic [LW-1:0]     remain;
    logic              op_wr;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic [TAG_W-1:0]  op_tag;

    assign busy = (remain != '0);

    // Count down the current operation, complete it, or start a new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain    <= '0;
            op_wr     <= 1'b0;
            op_addr   <= '0;
            op_data   <= '0;
            op_tag    <= '0;
            rsp_valid <= 1'b0;
            rsp_tag   <= '0;
            rsp_data  <= '0;
            for (int w = 0; w < WORDS; w++) cells[w] <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (remain == LW'(1)) begin
                remain <= '0;
                if (op_wr) begin
                    cells[op_addr] <= op_data;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_tag   <= op_tag;
                    rsp_data  <= cells[op_addr];
                end
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end else if (issue_valid) begin
                remain  <= issue_write ? LW'(WR_LAT) : LW'(RD_LAT);
                op_wr   <= issue_write;
                op_addr <= issue_addr;
                op_data <= issue_wdata;
                op_tag  <= issue_tag;
            end
        end
    end

    a_r8_single_operation: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !busy);
    a_r9_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == LW'(1) && !op_wr) |=> rsp_valid);

endmodule

// File: rtl/asym_bank_scheduler.sv
// Per-bank scheduler for a memory whose writes are much slower than its reads.
// Requests are split into a read queue and a write queue. When the bank is
// idle, one action is chosen per cycle:
//   - forced write (occupancy at the high-water mark), or
//   - the head read (answered from the write queue on a hit, sent to the bank
//     otherwise), or
//   - the oldest write.
// Responses come either from the bank model or from the forwarding register;
// the two can never coincide.
// Assumes: depths of at least 2, HIGH_PCT in 1..100, latencies of at least 1.
module asym_bank_scheduler
    import asym_sched_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 4,
    parameter int RDQ_DEPTH = 32,
    parameter int WRQ_DEPTH = 32,
    parameter int HIGH_PCT  = 80,
    parameter int RD_LAT    = 1000,
    parameter int WR_LAT    = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              issue_valid,
    output logic              issue_write,
    output logic              issue_forced,
    output logic [ADDR_W-1:0] issue_addr,
    output logic [DATA_W-1:0] issue_wdata,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int WCW       = $clog2(WRQ_DEPTH + 1);
    localparam int RD_W      = ADDR_W + TAG_W;
    localparam int HIGH_MARK = high_mark(WRQ_DEPTH, HIGH_PCT);
    localparam logic [WCW-1:0] HIGH_Q = WCW'(HIGH_MARK);

    sched_act_e        act;
    logic              rd_push, rd_pop, rd_empty, rd_full;
    logic [RD_W-1:0]   rd_head;
    logic [ADDR_W-1:0] rd_head_addr;
    logic [TAG_W-1:0]  rd_head_tag;
    logic              wr_push, wr_pop, wr_empty, wr_full;
    logic [ADDR_W-1:0] wr_head_addr;
    logic [DATA_W-1:0] wr_head_data;
    logic [WCW-1:0]    wr_count;
    logic              hit;
    logic [DATA_W-1:0] hit_data;
    logic              forced;
    logic              bank_busy, bank_rsp_v;
    logic [TAG_W-1:0]  bank_rsp_tag;
    logic [DATA_W-1:0] bank_rsp_data;
    logic              fwd_v;
    logic [TAG_W-1:0]  fwd_tag;
    logic [DATA_W-1:0] fwd_data;

    assign req_ready    = !rd_full && !wr_full;
    assign rd_push      = req_valid && req_ready && !req_write;
    assign wr_push      = req_valid && req_ready && req_write;
    assign rd_head_addr = rd_head[RD_W-1:TAG_W];
    assign rd_head_tag  = rd_head[TAG_W-1:0];
    assign forced       = (wr_count >= HIGH_Q);

    sched_rd_fifo #(.DEPTH(RDQ_DEPTH), .WIDTH(RD_W)) u_rdq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_push),
        .push_data ({req_addr, req_tag}),
        .pop       (rd_pop),
        .head_data (rd_head),
        .empty     (rd_empty),
        .full      (rd_full)
    );

    sched_wr_queue #(.DEPTH(WRQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wrq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .pop       (wr_pop),
        .head_addr (wr_head_addr),
        .head_data (wr_head_data),
        .empty     (wr_empty),
        .full      (wr_full),
        .count     (wr_count),
        .look_addr (rd_head_addr),
        .look_hit  (hit),
        .look_data (hit_data)
    );

    // Pick this cycle's service action from queue state and bank availability.
    always_comb begin
        act = ACT_NONE;
        if (!bank_busy) begin
            if (forced && !wr_empty) begin
                act = ACT_WR_BANK;
            end else if (!rd_empty) begin
                act = hit ? ACT_FORWARD : ACT_RD_BANK;
            end else if (!wr_empty) begin
                act = ACT_WR_BANK;
            end
        end
    end

    assign rd_pop       = (act == ACT_RD_BANK) || (act == ACT_FORWARD);
    assign wr_pop       = (act == ACT_WR_BANK);
    assign issue_valid  = (act == ACT_RD_BANK) || (act == ACT_WR_BANK);
    assign issue_write  = (act == ACT_WR_BANK);
    assign issue_forced = (act == ACT_WR_BANK) && forced;
    assign issue_addr   = issue_write ? wr_head_addr : rd_head_addr;
    assign issue_wdata  = wr_head_data;

    sched_bank_model #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .RD_LAT (RD_LAT),
        .WR_LAT (WR_LAT)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_write (issue_write),
        .issue_addr  (issue_addr),
        .issue_wdata (issue_wdata),
        .issue_tag   (rd_head_tag),
        .busy        (bank_busy),
        .rsp_valid   (bank_rsp_v),
        .rsp_tag     (bank_rsp_tag),
        .rsp_data    (bank_rsp_data)
    );

    // Register a response answered from the write queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_v    <= 1'b0;
            fwd_tag  <= '0;
            fwd_data <= '0;
        end else begin
            fwd_v    <= (act == ACT_FORWARD);
            fwd_tag  <= rd_head_tag;
            fwd_data <= hit_data;
        end
    end

    assign rsp_valid = bank_rsp_v || fwd_v;
    assign rsp_tag   = bank_rsp_v ? bank_rsp_tag  : fwd_tag;
    assign rsp_data  = bank_rsp_v ? bank_rsp_data : fwd_data;

    a_r10_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_v |-> !bank_rsp_v);
    a_r2_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_busy && !forced && !rd_empty) |-> !(issue_valid && issue_write));
    a_r3_forced_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_busy && forced) |-> (issue_valid && issue_write && issue_forced));
    a_r7_ready_tracks_full: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rd_full && wr_count < WCW'(WRQ_DEPTH)));

endmodule

// File: tb/asym_bank_scheduler_bench.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module asym_bank_scheduler_bench;
    localparam int AW = 4, DW = 16, TW = 4;
    localparam int RDQ = 4, WRQ = 8, PCT = 80, RL = 3, WL = 12;
    localparam int HIGH = (WRQ * PCT + 99) / 100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [TW-1:0] req_tag = '0;
    logic req_ready, issue_valid, issue_write, issue_forced, rsp_valid;
    logic [AW-1:0] issue_addr;
    logic [DW-1:0] issue_wdata, rsp_data;
    logic [TW-1:0] rsp_tag;

    asym_bank_scheduler #(
        .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .RDQ_DEPTH(RDQ), .WRQ_DEPTH(WRQ),
        .HIGH_PCT(PCT), .RD_LAT(RL), .WR_LAT(WL)
    ) u_asym_bank_scheduler (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_tag(req_tag), .issue_valid(issue_valid), .issue_write(issue_write),
        .issue_forced(issue_forced), .issue_addr(issue_addr),
        .issue_wdata(issue_wdata), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_data(rsp_data)
    );

    always #10 clk = ~clk;   // 20-unit period: 50 MHz

    typedef struct { int addr; int data; bit merged; } went_t;
    typedef struct { int addr; int tag; } rent_t;
    went_t wq[$];
    rent_t rq[$];
    int mem [16];
    int b_cnt = 0, b_addr = 0, b_data = 0, b_tag = 0;
    bit b_wr = 0;
    bit e_rsp_v = 0, e_rsp_fwd = 0;
    int e_rsp_tag = 0, e_rsp_data = 0;
    int checks = 0, errors = 0, tag_ctr = 0;
    int n_forced = 0, n_fwd = 0, n_merged = 0, n_full = 0;
    bit done = 0;

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // One cycle: compare at the negedge, drive inputs, advance the model.
    task automatic step(bit v, bit w, int a, int d);
        int act;
        bit forced, hit, e_ready, e_iv, e_iw, e_if;
        int hdata, e_ia, e_id;
        string tag;
        e_ready = (rq.size() < RDQ) && (wq.size() < WRQ);
        forced  = (wq.size() >= HIGH);
        hit = 0; hdata = 0;
        if (rq.size() > 0)
            for (int i = wq.size() - 1; i >= 0; i--)
                if (wq[i].addr == rq[0].addr) begin hit = 1; hdata = wq[i].data; break; end
        act = 0;
        if (b_cnt == 0) begin
            if (forced && wq.size() > 0) act = 2;
            else if (rq.size() > 0) act = hit ? 3 : 1;
            else if (wq.size() > 0) act = 2;
        end
        // R7: ready reflects both queues' fullness
        chk("R7", "req_ready", int'(req_ready), int'(e_ready));
        if (!e_ready) n_full++;
        e_iv = (act == 1 || act == 2);
        e_iw = (act == 2);
        e_if = (act == 2) && forced;
        e_ia = (act == 2) ? wq[0].addr : (act == 1 ? rq[0].addr : 0);
        e_id = (act == 2) ? wq[0].data : 0;
        if (b_cnt != 0) tag = "R8";
        else if (e_if) tag = "R3";
        else if (act == 2 && wq[0].merged) tag = "R6";
        else if (act == 2) tag = "R4";
        else if (act == 3) tag = "R5";
        else tag = "R2";
        chk(tag, "issue_valid", int'(issue_valid), int'(e_iv));
        if (e_iv && issue_valid) begin
            chk(tag, "issue_write", int'(issue_write), int'(e_iw));
            chk(tag, "issue_forced", int'(issue_forced), int'(e_if));
            chk(tag, "issue_addr", int'(issue_addr), e_ia);
            if (e_iw) chk(tag, "issue_wdata", int'(issue_wdata), e_id);
        end
        if (e_if) n_forced++;
        if (act == 3) n_fwd++;
        if (act == 2 && wq[0].merged) n_merged++;
        chk(e_rsp_fwd ? "R5" : "R9", "rsp_valid", int'(rsp_valid), int'(e_rsp_v));
        if (e_rsp_v && rsp_valid) begin
            chk("R10", "rsp_tag", int'(rsp_tag), e_rsp_tag);
            chk(e_rsp_fwd ? "R5" : "R10", "rsp_data", int'(rsp_data), e_rsp_data);
        end
        // drive
        req_valid = v; req_write = w; req_addr = a[AW-1:0];
        req_wdata = d[DW-1:0]; req_tag = tag_ctr[TW-1:0];
        // model edge
        e_rsp_v = 0; e_rsp_fwd = 0;
        if (b_cnt == 1) begin
            b_cnt = 0;
            if (b_wr) mem[b_addr] = b_data;
            else begin e_rsp_v = 1; e_rsp_tag = b_tag; e_rsp_data = mem[b_addr]; end
        end else if (b_cnt > 1) begin
            b_cnt--;
        end else if (act == 1) begin
            b_cnt = RL; b_wr = 0; b_addr = rq[0].addr; b_tag = rq[0].tag; void'(rq.pop_front());
        end else if (act == 2) begin
            b_cnt = WL; b_wr = 1; b_addr = wq[0].addr; b_data = wq[0].data; void'(wq.pop_front());
        end else if (act == 3) begin
            e_rsp_v = 1; e_rsp_fwd = 1; e_rsp_tag = rq[0].tag; e_rsp_data = hdata;
            void'(rq.pop_front());
        end
        if (v && e_ready) begin
            if (w) begin
                bit found = 0;
                for (int i = 0; i < wq.size(); i++)
                    if (wq[i].addr == a) begin
                        went_t e = wq[i];
                        e.data = d; e.merged = 1; wq[i] = e; found = 1;
                    end
                if (!found) wq.push_back('{a, d, 1'b0});
            end else begin
                rq.push_back('{a, tag_ctr % 16});
                tag_ctr++;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "issue_valid", int'(issue_valid), 0);
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        // reads of never-written words
        for (int i = 0; i < 4; i++) step(1, 0, i, 0);
        idle(20);
        // writes queued, then reads: priority and forwarding
        step(1, 1, 1, 'h11); step(1, 1, 2, 'h22); step(1, 1, 3, 'h33);
        step(1, 0, 2, 0); step(1, 0, 5, 0);
        idle(60);
        // merges into a queued write
        step(1, 1, 7, 'hA1); step(1, 1, 7, 'hA2); step(1, 1, 8, 'hB0);
        step(1, 1, 7, 'hA3); step(1, 0, 7, 0);
        idle(60);
        // write flood towards forced draining and full queues
        for (int i = 0; i < 24; i++) begin
            if (i % 4 == 3) step(1, 0, i % 16, 0);
            else step(1, 1, i % 16, 'h100 + i);
        end
        idle(200);
        // reads pile up behind a write in progress
        step(1, 1, 9, 'h99);
        for (int i = 0; i < 6; i++) step(1, 0, 10 + (i % 3), 0);
        idle(60);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(99);
            step(r < 60, $urandom_range(1) == 1, $urandom_range(15), $urandom_range(16'hFFFF));
        end
        idle(400);
        chk("R3", "forced writes seen", int'(n_forced > 0), 1);
        chk("R5", "forwarded reads seen", int'(n_fwd > 0), 1);
        chk("R6", "merged writes seen", int'(n_merged > 0), 1);
        chk("R7", "full cycles seen", int'(n_full > 0), 1);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R8 watchdog: got 0 expected 1 (run did not end)");
            finish_run();
        end
    end
endmodule